// File: doc/BRIEF.md
# Scannable Transmit/Receive Sequencing Controller

This block is a six-state controller that paces a serial port's character buffers. It reads three status inputs: transmit holding register empty, receive buffer full, and a flag that says the outgoing character is a carriage return. From these it raises strobes that load and clear the transmitter, write a received character into memory, step the transmit or receive address, steer the address multiplexer and clear the shared address. Some strobes depend only on the current state. Others also depend on an input.

The state register uses an almost one-hot code. The reset state is all zeros, and each of the other five states sets exactly one flip-flop. Each flip-flop sits behind a 2:1 multiplexer, and together they form a serial scan chain. With the scan enable high, every clock edge shifts the chain by one place. With it low, the same edge applies the next-state logic. To test one transition, shift a state in, lower the scan enable for one clock, then shift the result out.

Top module: `scan_seq_fsm`

## Requirements
- R1: The state register has five bits. The reset state is 00000. The wait-for-transmit state is bit 0, the first carriage-return check is bit 1, the wait-for-receive state is bit 2, the second wait-for-transmit state is bit 3 and the second carriage-return check is bit 4.
- R2: Reset is synchronous and active low. Any rising edge with `rst_n` low clears the state to 00000, even when `scan_en` is high.
- R3: In the reset state, `addr_clear` is 1 and every other strobe is 0. The next functional edge always goes to the wait-for-transmit state.
- R4: The wait-for-transmit state stays put while `tx_empty` is 0. When `tx_empty` is 1, `tx_load`, `tx_flag_clear` and `addr_select` are 1 and the next state is the first carriage-return check.
- R5: In the first carriage-return check with `cr_match` 0, `tx_addr_inc` and `addr_select` are 1 and the machine returns to wait-for-transmit. With `cr_match` 1, no strobe is raised and the next state is wait-for-receive.
- R6: The wait-for-receive state stays put while `rx_full` is 0. When `rx_full` is 1, `rx_write` and `rx_flag_clear` are 1 and the next state is the second wait-for-transmit state.
- R7: The second wait-for-transmit state stays put while `tx_empty` is 0. When `tx_empty` is 1, `tx_load` and `tx_flag_clear` are 1 and the next state is the second carriage-return check.
- R8: In the second carriage-return check with `cr_match` 0, `rx_addr_inc` is 1 and the next state is wait-for-receive. With `cr_match` 1, `addr_clear` is 1 and the next state is wait-for-transmit.
- R9: While `scan_en` is 1, each edge moves `scan_di` into bit 0 and bit k into bit k+1, and the next-state logic is ignored. `scan_do` always shows bit 4. After five shifts, the first bit shifted in sits in bit 4.
- R10: A state ignores the inputs it does not test. Toggling those inputs changes neither the strobes nor the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both functional steps and scan shifts |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | 1 shifts the chain, 0 applies the next-state logic |
| scan_di | input | 1 | Serial scan data into bit 0 |
| tx_empty | input | 1 | Transmit holding register empty |
| rx_full | input | 1 | Receive buffer holds a character |
| cr_match | input | 1 | Outgoing character is a carriage return |
| addr_clear | output | 1 | Clear the buffer address |
| tx_load | output | 1 | Load the transmit holding register |
| tx_flag_clear | output | 1 | Clear the transmit-empty flag |
| rx_write | output | 1 | Write the received character to memory |
| rx_flag_clear | output | 1 | Clear the receive-full flag |
| tx_addr_inc | output | 1 | Step the transmit address |
| rx_addr_inc | output | 1 | Step the receive address |
| addr_select | output | 1 | Steer the address multiplexer to the transmit address |
| scan_do | output | 1 | Serial scan data from bit 4 |

## Verification
A wrong state bit shows up at the strobes in the same cycle the state is loaded, because every strobe is a decode of the state and the inputs with no register in between. It shows up on `scan_do` within five shifts. A missing or wrong transition is invisible until the next functional edge. After that edge it appears either as a wrong strobe on the following cycle or as a wrong bit when the state is shifted out. Each transition is therefore tested in isolation: load a state, take one functional step, then unload the state. An illegal code that has been shifted in can make several strobes fire at once, so the strobes are only compared while `scan_en` is low and a legal code is loaded.

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic scan_di,
  input  logic tx_empty,
  input  logic rx_full,
  input  logic cr_match,
  output logic addr_clear,
  output logic tx_load,
  output logic tx_flag_clear,
  output logic rx_write,
  output logic rx_flag_clear,
  output logic tx_addr_inc,
  output logic rx_addr_inc,
  output logic addr_select,
  output logic scan_do
);

  localparam int NFF      = 5;
  localparam int B_WTX    = 0;
  localparam int B_CR1    = 1;
  localparam int B_WRX    = 2;
  localparam int B_WTX2   = 3;
  localparam int B_CR2    = 4;

  logic [NFF-1:0] st, nxt, d;
  logic in_start, in_wtx, in_cr1, in_wrx, in_wtx2, in_cr2;

  assign in_start = ~|st;
  assign in_wtx   = st[B_WTX];
  assign in_cr1   = st[B_CR1];
  assign in_wrx   = st[B_WRX];
  assign in_wtx2  = st[B_WTX2];
  assign in_cr2   = st[B_CR2];

  assign nxt[B_WTX]  = in_start | (in_wtx & ~tx_empty) | (in_cr1 & ~cr_match) | (in_cr2 & cr_match);
  assign nxt[B_CR1]  = in_wtx & tx_empty;
  assign nxt[B_WRX]  = (in_cr1 & cr_match) | (in_wrx & ~rx_full) | (in_cr2 & ~cr_match);
  assign nxt[B_WTX2] = (in_wrx & rx_full) | (in_wtx2 & ~tx_empty);
  assign nxt[B_CR2]  = in_wtx2 & tx_empty;

  for (genvar i = 0; i < NFF; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign d[i] = scan_en ? scan_di : nxt[i];
    end else begin : g_link
      assign d[i] = scan_en ? st[i-1] : nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= d;
  end

  assign scan_do       = st[NFF-1];
  assign addr_clear    = in_start | (in_cr2 & cr_match);
  assign tx_load       = (in_wtx | in_wtx2) & tx_empty;
  assign tx_flag_clear = (in_wtx | in_wtx2) & tx_empty;
  assign rx_write      = in_wrx & rx_full;
  assign rx_flag_clear = in_wrx & rx_full;
  assign tx_addr_inc   = in_cr1 & ~cr_match;
  assign rx_addr_inc   = in_cr2 & ~cr_match;
  assign addr_select   = (in_wtx & tx_empty) | (in_cr1 & ~cr_match);

endmodule

// File: rtl/scan_seq_fsm_chk.sv
module scan_seq_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scan_en,
  input logic       scan_di,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       cr_match,
  input logic       addr_clear,
  input logic       tx_load,
  input logic       tx_flag_clear,
  input logic       rx_write,
  input logic       addr_select,
  input logic       scan_do,
  input logic [4:0] st
);

  a_r2_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> st == 5'b00000);

  a_r9_shift: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scan_en) && $past(rst_n)) |-> st == {$past(st[3:0]), $past(scan_di)});

  a_r9_scan_out: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> scan_do == $past(st[3]));

  a_r3_start_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && st == 5'b00000) |-> addr_clear);

  a_r3_start_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && st == 5'b00000) |=> st == 5'b00001);

  a_r4_load_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && st == 5'b00001 && tx_empty) |-> (tx_load && tx_flag_clear && addr_select));

  a_r4_to_check: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && st == 5'b00001 && tx_empty) |=> st == 5'b00010);

  a_r6_to_wait_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && st == 5'b00100 && rx_full) |=> st == 5'b01000);

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && st == 5'b10000 && cr_match) |=> st == 5'b00001);

  a_r1_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && $onehot0(st)) |=> $onehot0(st));

  a_r10_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && $onehot0(st)) |-> !(rx_write && tx_load));

endmodule

bind scan_seq_fsm scan_seq_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_di(scan_di),
  .tx_empty(tx_empty), .rx_full(rx_full), .cr_match(cr_match),
  .addr_clear(addr_clear), .tx_load(tx_load), .tx_flag_clear(tx_flag_clear),
  .rx_write(rx_write), .addr_select(addr_select), .scan_do(scan_do), .st(st)
);

// File: tb/scan_seq_fsm_test.sv
module scan_seq_fsm_test;

  logic clk = 1'b0;
  logic rst_n, scan_en, scan_di, tx_empty, rx_full, cr_match;
  logic addr_clear, tx_load, tx_flag_clear, rx_write, rx_flag_clear;
  logic tx_addr_inc, rx_addr_inc, addr_select, scan_do;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  scan_seq_fsm uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_di(scan_di),
    .tx_empty(tx_empty), .rx_full(rx_full), .cr_match(cr_match),
    .addr_clear(addr_clear), .tx_load(tx_load), .tx_flag_clear(tx_flag_clear),
    .rx_write(rx_write), .rx_flag_clear(rx_flag_clear), .tx_addr_inc(tx_addr_inc),
    .rx_addr_inc(rx_addr_inc), .addr_select(addr_select), .scan_do(scan_do)
  );

  logic [7:0] outs;
  assign outs = {addr_clear, tx_load, tx_flag_clear, rx_write,
                 rx_flag_clear, tx_addr_inc, rx_addr_inc, addr_select};

  // fields: [20:16] state, [15] tx_empty, [14] rx_full, [13] cr_match, [12:5] strobes, [4:0] next
  localparam logic [20:0] TBL [12] = '{
    {5'b00000, 3'b000, 8'b1000_0000, 5'b00001},
    {5'b00000, 3'b111, 8'b1000_0000, 5'b00001},
    {5'b00001, 3'b011, 8'b0000_0000, 5'b00001},
    {5'b00001, 3'b100, 8'b0110_0001, 5'b00010},
    {5'b00010, 3'b110, 8'b0000_0101, 5'b00001},
    {5'b00010, 3'b001, 8'b0000_0000, 5'b00100},
    {5'b00100, 3'b101, 8'b0000_0000, 5'b00100},
    {5'b00100, 3'b010, 8'b0001_1000, 5'b01000},
    {5'b01000, 3'b011, 8'b0000_0000, 5'b01000},
    {5'b01000, 3'b100, 8'b0110_0000, 5'b10000},
    {5'b10000, 3'b110, 8'b0000_0010, 5'b00100},
    {5'b10000, 3'b001, 8'b1000_0000, 5'b00001}
  };
  string tags [12] = '{"R3", "R10", "R10", "R4", "R5", "R5",
                       "R10", "R6", "R10", "R7", "R8", "R8"};

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
  endtask

  task automatic scan_load(logic [4:0] v);
    scan_en = 1'b1;
    for (int i = 4; i >= 0; i--) begin
      scan_di = v[i];
      tick();
    end
    scan_en = 1'b0;
    scan_di = 1'b0;
  endtask

  task automatic scan_read(output logic [4:0] v);
    scan_en = 1'b1;
    scan_di = 1'b0;
    for (int i = 4; i >= 0; i--) begin
      v[i] = scan_do;
      tick();
    end
    scan_en = 1'b0;
  endtask

  task automatic set_in(logic t, logic r, logic x);
    tx_empty = t;
    rx_full  = r;
    cr_match = x;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] got;
    rst_n = 1'b0; scan_en = 1'b0; scan_di = 1'b0;
    set_in(1'b0, 1'b0, 1'b0);
    tick(); tick();
    rst_n = 1'b1;
    #1;
    chk("R3", "strobes after reset", outs, 8'b1000_0000);
    scan_read(got);
    chk("R1", "state after reset", {3'b0, got}, 8'b0000_0000);

    for (int k = 0; k < 12; k++) begin
      do_reset();
      scan_load(TBL[k][20:16]);
      set_in(TBL[k][15], TBL[k][14], TBL[k][13]);
      #1;
      chk(tags[k], $sformatf("strobes entry %0d", k), outs, TBL[k][12:5]);
      tick();
      set_in(1'b0, 1'b0, 1'b0);
      scan_read(got);
      chk(tags[k], $sformatf("next state entry %0d", k), {3'b0, got}, {3'b0, TBL[k][4:0]});
    end

    scan_load(5'b11111);
    rst_n = 1'b0; scan_en = 1'b1; scan_di = 1'b1;
    tick();
    rst_n = 1'b1; scan_en = 1'b0;
    scan_read(got);
    chk("R2", "reset beats scan", {3'b0, got}, 8'b0000_0000);

    do_reset();
    set_in(1'b1, 1'b1, 1'b1);
    scan_load(5'b00001);
    scan_read(got);
    chk("R9", "shift ignores next-state logic", {3'b0, got}, 8'b0000_0001);
    set_in(1'b0, 1'b0, 1'b0);

    do_reset();
    begin
      logic [9:0] pat;
      logic [4:0] seen;
      pat = 10'b10110_00000;
      scan_en = 1'b1;
      for (int i = 0; i < 10; i++) begin
        if (i >= 5) seen[9 - i] = scan_do;
        scan_di = pat[9 - i];
        tick();
      end
      scan_en = 1'b0;
      chk("R9", "five-stage pass-through", {3'b0, seen}, 8'b0001_0110);
    end

    do_reset();
    set_in(1'b0, 1'b0, 1'b0);
    tick();
    tick();
    set_in(1'b1, 1'b0, 1'b0); tick();
    set_in(1'b0, 1'b0, 1'b0); #1;
    chk("R5", "walk retry strobes", outs, 8'b0000_0101);
    tick();
    set_in(1'b1, 1'b0, 1'b0); tick();
    set_in(1'b0, 1'b0, 1'b1); tick();
    set_in(1'b0, 1'b1, 1'b0); tick();
    set_in(1'b1, 1'b0, 1'b0); tick();
    set_in(1'b0, 1'b0, 1'b1); #1;
    chk("R8", "walk wrap strobes", outs, 8'b1000_0000);
    tick();
    set_in(1'b0, 1'b0, 1'b0);
    scan_read(got);
    chk("R8", "walk end state", {3'b0, got}, 8'b0000_0001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule